// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Compare Output

This block is an 8-bit up-counter that advances on enables from a clock divider. The divider has seven ratios and a stop setting. Software picks one of three waveform modes. Normal mode counts freely and wraps. Clear-on-compare (CTC) mode restarts the count after it matches a compare value. Fast PWM mode counts once from 0x00 to 0xFF per period. One waveform bit is derived from compare and wrap events and is driven onto a single output pin. The pin shows the waveform only when its direction input asks for output and the selected output mode is connected. Otherwise the pin shows the port level.

Software reaches the block through a write-only strobe interface (`wr_en`, `wr_addr`, `wr_data`). Each strobe is accepted in the cycle it is raised, with no back-pressure and no handshake. The block presents its count, two sticky event flags and the pin level as plain outputs.

The register map is as follows:
- Address 0 is the control register. Bits [2:0] hold the divider select, bits [4:3] the waveform mode and bits [6:5] the output mode.
- Address 1 writes the count.
- Address 2 writes the compare value.
- Address 3 clears flags: a 1 in bit 0 clears the overflow flag and a 1 in bit 1 clears the compare flag.

Top module: `tmr8_pwm`

## Requirements
- R1: Divider select 0 stops the count. Selects 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. A control write restarts the divider phase, so the first tick falls on the Nth clock edge after the write edge.
- R2: In waveform mode 0 (normal; code 2 behaves the same), each tick adds one to the count and 0xFF wraps to 0x00. The overflow flag rises on the edge where the count leaves 0xFF.
- R3: In waveform mode 1 (CTC), a tick while the count equals the compare value loads 0x00 and sets the compare flag. The period is therefore compare+1 ticks.
- R4: Outside PWM mode, a compare match acts on the waveform according to the output mode:
  - 01 toggles the waveform.
  - 10 clears the waveform.
  - 11 sets the waveform.
- R5: In CTC mode, a compare value written below the present count gives no match on that pass. The count runs to 0xFF, wraps to 0x00 with the overflow flag, and only then matches.
- R6: Waveform mode 3 (fast PWM) counts 0x00 to 0xFF and restarts, with the overflow flag set at each restart. With output mode 10 (non-inverting), the waveform is 1 exactly while count <= active compare value.
- R7: In fast PWM with output mode 11 (inverting), the waveform is the complement of R6: it is 0 while count <= active compare value.
- R8: In fast PWM, a compare write only fills a buffer, and the active value loads from the buffer on the edge where the count leaves 0xFF. In other modes a compare write takes effect at once.
- R9: The pin carries the waveform only when `pin_dir` is 1 and the output mode is connected: any non-zero output mode, except that 01 is not connected in fast PWM. In every other case the pin equals `port_level`.
- R10: Both flags are sticky until software writes 1 to their bit at address 3. A flag set event in the same cycle as a clear wins.
- R11: A count write loads the written value in place of that cycle's tick, and no compare match or overflow is taken in that cycle.
- R12: After reset, all of these are 0: the count, the compare value, the control register, both flags and the waveform. The timer is therefore stopped and the pin shows `port_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address (0 control, 1 count, 2 compare, 3 flag clear) |
| wr_data | input | 8 | Write data |
| pin_dir | input | 1 | 1 selects output direction for the pin |
| port_level | input | 1 | Level shown on the pin when the waveform is not routed |
| pin_out | output | 1 | Pin level |
| count_o | output | 8 | Present count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
The assertions assume these things about the inputs:
- Writes arrive as single-cycle strobes synchronous to `clk`.
- The divider select changes only through a control write, which also restarts the divider.
- `pin_dir` and `port_level` are synchronous levels.

The bench drives every input on the falling edge and issues at most one write per cycle. It stops the timer before it loads the count or compare value, so each scenario starts from a known count and divider phase.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_CTC     = 2'd1,
    WM_ALT     = 2'd2,
    WM_FASTPWM = 2'd3
  } wmode_e;

  localparam logic [1:0] OM_OFF = 2'd0;
  localparam logic [1:0] OM_TOG = 2'd1;
  localparam logic [1:0] OM_LO  = 2'd2;
  localparam logic [1:0] OM_HI  = 2'd3;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_FLAGS = 2'd3;

  // log2 of the divide ratio for each select code
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    div_shift = 3;
      3'd3:    div_shift = 5;
      3'd4:    div_shift = 6;
      3'd5:    div_shift = 7;
      3'd6:    div_shift = 8;
      3'd7:    div_shift = 10;
      default: div_shift = 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = ~({PRE_W{1'b1}} << div_shift(sel));
    tick = (sel != 3'd0) && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R1: ratios above one never give two ticks in a row
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel > 3'd1 && !restart) |=> !tick);
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wmode_e           wmode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wd,
  input  logic             clr_we,
  input  logic [1:0]       clr_wd,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             bottom_ev,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cmp_buf, cmp_act;
  logic is_pwm, is_ctc, live, hit;

  always_comb begin
    is_pwm    = (wmode == WM_FASTPWM);
    is_ctc    = (wmode == WM_CTC);
    live      = tick && !cnt_we;
    hit       = (cnt == cmp_act);
    match_ev  = live && hit;
    bottom_ev = live && (cnt == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp_buf  <= '0;
      cmp_act  <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (cnt_we)                cnt <= cnt_wd;
      else if (live && is_ctc && hit) cnt <= '0;
      else if (live)             cnt <= cnt + 1'b1;

      if (cmp_we) cmp_buf <= cmp_wd;
      if (cmp_we && !is_pwm)         cmp_act <= cmp_wd;
      else if (is_pwm && bottom_ev)  cmp_act <= cmp_buf;

      ovf_flag <= bottom_ev || (ovf_flag && !(clr_we && clr_wd[0]));
      cmp_flag <= match_ev  || (cmp_flag && !(clr_we && clr_wd[1]));
    end
  end

  // R1: no tick and no write leaves the count unchanged
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));
  // R3: a CTC match restarts the count and raises the compare flag
  p_ctc_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctc && tick && !cnt_we && cnt == cmp_act) |=> (cnt == '0 && cmp_flag));
  // R2: leaving the top value raises the overflow flag
  p_wrap_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == TOP) |=> ovf_flag);
  // R8: in PWM the active compare value moves only at the wrap
  p_buffered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && !(tick && !cnt_we && cnt == TOP)) |=> $stable(cmp_act));
  // R11: a count write always lands
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt == $past(cnt_wd) && !$rose(cmp_flag)));
  // R10: a flag stays set unless its clear bit is written
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(clr_we && clr_wd[0])) |=> ovf_flag);
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_pwm,
  input  logic [1:0] om,
  input  logic       match_ev,
  input  logic       bottom_ev,
  output logic       wave,
  output logic       drive
);
  always_comb drive = (om != OM_OFF) && !(is_pwm && om == OM_TOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else if (is_pwm) begin
      if (bottom_ev && om[1])     wave <= ~om[0];
      else if (match_ev && om[1]) wave <= om[0];
    end else if (match_ev) begin
      case (om)
        OM_TOG:  wave <= ~wave;
        OM_LO:   wave <= 1'b0;
        OM_HI:   wave <= 1'b1;
        default: wave <= wave;
      endcase
    end
  end

  // R4: toggle mode flips the waveform on every match
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pwm && om == OM_TOG && match_ev) |=> (wave != $past(wave)));
  // R6: non-inverting PWM is high after the restart
  p_pwm_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && om == OM_LO && bottom_ev) |=> wave);
  // R7: inverting PWM is low after the restart
  p_pwm_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && om == OM_HI && bottom_ev) |=> !wave);
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pin_dir,
  input  logic             port_level,
  output logic             pin_out,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o
);
  logic [2:0] sel_q;
  logic [1:0] wm_q, om_q;
  logic       ctrl_we, tick, match_ev, bottom_ev, wave, drive;
  wmode_e     wmode;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == A_CTRL);
    wmode   = wmode_e'(wm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      wm_q  <= '0;
      om_q  <= '0;
    end else if (ctrl_we) begin
      sel_q <= wr_data[2:0];
      wm_q  <= wr_data[4:3];
      om_q  <= wr_data[6:5];
    end
  end

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_we), .sel(sel_q), .tick(tick)
  );

  tmr8_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wmode(wmode),
    .cnt_we(wr_en && wr_addr == A_COUNT), .cnt_wd(wr_data),
    .cmp_we(wr_en && wr_addr == A_CMP), .cmp_wd(wr_data),
    .clr_we(wr_en && wr_addr == A_FLAGS), .clr_wd(wr_data[1:0]),
    .cnt(count_o), .match_ev(match_ev), .bottom_ev(bottom_ev),
    .ovf_flag(ovf_flag_o), .cmp_flag(cmp_flag_o)
  );

  tmr8_wave u_wave (
    .clk(clk), .rst_n(rst_n), .is_pwm(wmode == WM_FASTPWM), .om(om_q),
    .match_ev(match_ev), .bottom_ev(bottom_ev), .wave(wave), .drive(drive)
  );

  always_comb pin_out = (pin_dir && drive) ? wave : port_level;
endmodule

// File: tb/tmr8_pwm_tb.sv
`timescale 1ns/1ps
module tmr8_pwm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pin_dir = 1'b0;
  logic       port_level = 1'b0;
  logic       pin_out, ovf, cmpf;
  logic [7:0] cnt;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr8_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_dir(pin_dir), .port_level(port_level), .pin_out(pin_out),
    .count_o(cnt), .ovf_flag_o(ovf), .cmp_flag_o(cmpf)
  );

  function automatic logic [7:0] cfg(input logic [1:0] om, input logic [1:0] wm,
                                     input logic [2:0] sel);
    return {1'b0, om, wm, sel};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    port_level = 1'b1; pin_dir = 1'b1;
    #0;
    chk("R12 count", cnt, 0);
    chk("R12 ovf", ovf, 0);
    chk("R12 cmp", cmpf, 0);
    chk("R12 pin", pin_out, 1);
    idle(20);
    chk("R1 stopped after reset", cnt, 0);
  endtask

  task automatic t_prescale;
    wr(A_CTRL_T, 8'h00); wr(2'd1, 8'h00); wr(A_CTRL_T, cfg(0, 0, 3'd2));
    idle(40);
    chk("R1 div8", cnt, 5);
    wr(A_CTRL_T, 8'h00); wr(2'd1, 8'h00); wr(A_CTRL_T, cfg(0, 0, 3'd7));
    idle(1023);
    chk("R1 div1024 early", cnt, 0);
    idle(1);
    chk("R1 div1024 first", cnt, 1);
    idle(1024);
    chk("R1 div1024 second", cnt, 2);
    wr(A_CTRL_T, 8'h00); wr(2'd1, 8'h00); wr(A_CTRL_T, cfg(0, 0, 3'd3));
    idle(96);
    chk("R1 div32", cnt, 3);
    wr(A_CTRL_T, 8'h00);
    begin
      int held = cnt;
      idle(50);
      chk("R1 select0 holds", cnt, held);
    end
  endtask

  localparam logic [1:0] A_CTRL_T = 2'd0;

  task automatic t_normal;
    wr(2'd3, 8'h03); wr(2'd1, 8'hFE); wr(A_CTRL_T, cfg(0, 0, 3'd1));
    idle(1);
    chk("R2 count FF", cnt, 8'hFF);
    chk("R2 no ovf yet", ovf, 0);
    idle(1);
    chk("R2 wrap", cnt, 0);
    chk("R2 ovf set", ovf, 1);
    // clear on match
    port_level = 1'b1;
    wr(A_CTRL_T, 8'h00); wr(2'd2, 8'h02); wr(2'd1, 8'h00); wr(A_CTRL_T, cfg(2'b10, 0, 3'd1));
    idle(3);
    chk("R4 clear on match", pin_out, 0);
    port_level = 1'b0;
    wr(A_CTRL_T, 8'h00); wr(2'd1, 8'h00); wr(A_CTRL_T, cfg(2'b11, 0, 3'd1));
    idle(3);
    chk("R4 set on match", pin_out, 1);
    wr(A_CTRL_T, 8'h00);
  endtask

  task automatic t_ctc;
    logic p0;
    wr(2'd2, 8'h03); wr(2'd1, 8'h00); wr(2'd3, 8'h03); wr(A_CTRL_T, cfg(2'b01, 1, 3'd1));
    p0 = pin_out;
    idle(3);
    chk("R3 count at compare", cnt, 3);
    chk("R3 no flag yet", cmpf, 0);
    idle(1);
    chk("R3 restart", cnt, 0);
    chk("R3 flag", cmpf, 1);
    chk("R4 toggle 1", pin_out, !p0);
    idle(3);
    chk("R10 sticky", cmpf, 1);
    wr(2'd3, 8'h02);
    chk("R10 set wins over clear", cmpf, 1);
    chk("R4 toggle 2", pin_out, p0);
    chk("R3 period", cnt, 0);
    wr(2'd3, 8'h02);
    chk("R10 cleared", cmpf, 0);
    chk("R10 other flag kept", ovf, 0);
    wr(A_CTRL_T, 8'h00);
  endtask

  task automatic t_missed;
    wr(2'd2, 8'h60); wr(2'd1, 8'h50); wr(2'd3, 8'h03); wr(A_CTRL_T, cfg(0, 1, 3'd1));
    idle(5);
    wr(2'd2, 8'h40);
    chk("R5 count after write", cnt, 8'h56);
    idle(8'hAA);
    chk("R5 wrapped", cnt, 0);
    chk("R5 ovf", ovf, 1);
    chk("R5 no match on pass", cmpf, 0);
    idle(8'h40);
    chk("R5 reaches compare", cnt, 8'h40);
    chk("R5 still no match", cmpf, 0);
    idle(1);
    chk("R5 match after wrap", cnt, 0);
    chk("R5 flag after wrap", cmpf, 1);
    wr(A_CTRL_T, 8'h00);
  endtask

  task automatic t_suppress;
    wr(2'd2, 8'h05); wr(2'd1, 8'h00); wr(2'd3, 8'h03); wr(A_CTRL_T, cfg(0, 1, 3'd1));
    idle(5);
    chk("R11 at compare", cnt, 5);
    wr(2'd1, 8'h10);
    chk("R11 write lands", cnt, 8'h10);
    chk("R11 match suppressed", cmpf, 0);
    idle(1);
    chk("R11 counting resumes", cnt, 8'h11);
    wr(A_CTRL_T, 8'h00);
  endtask

  task automatic pwm_run(input string tag, input logic [1:0] om, input logic [7:0] c0,
                         input logic [7:0] c1, input bit inv, input int n);
    logic [7:0] act, buf_v, nact, nbuf;
    int bad = 0;
    pin_dir = 1'b1; port_level = inv;
    wr(2'd2, c0); wr(2'd1, 8'hFF); wr(2'd3, 8'h03); wr(A_CTRL_T, cfg(om, 3, 3'd1));
    act = c0; buf_v = c0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        logic e;
        e = (cnt <= act) ^ inv;
        if (pin_out != e) begin
          bad++;
          if (bad < 4) chk(tag, pin_out, e);
        end
      end
      nact = (cnt == 8'hFF) ? buf_v : act;
      nbuf = buf_v;
      if (i == 100) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = c1; nbuf = c1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      act = nact; buf_v = nbuf;
    end
    wr_en = 1'b0;
    chk({tag, " no mismatch"}, bad, 0);
    chk("R6 pwm overflow flag", ovf, 1);
    wr(A_CTRL_T, 8'h00);
  endtask

  task automatic t_gating;
    pin_dir = 1'b1;
    wr(A_CTRL_T, cfg(2'b00, 0, 3'd0));
    port_level = 1'b1; #1 chk("R9 off mode shows port", pin_out, 1);
    port_level = 1'b0; #1 chk("R9 off mode shows port", pin_out, 0);
    wr(2'd1, 8'hFF); wr(2'd2, 8'h80);
    wr(A_CTRL_T, cfg(2'b10, 3, 3'd1));
    idle(4);
    chk("R9 pwm routed high", pin_out, 1);
    port_level = 1'b0;
    wr(A_CTRL_T, cfg(2'b01, 3, 3'd0));
    chk("R9 toggle code not routed in pwm", pin_out, 0);
    wr(A_CTRL_T, cfg(2'b10, 3, 3'd0));
    pin_dir = 1'b0; #1
    chk("R9 input direction shows port", pin_out, 0);
    wr(A_CTRL_T, 8'h00);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_prescale;
    t_normal;
    t_ctc;
    t_missed;
    t_suppress;
    pwm_run("R6 R8 non-inverting", 2'b10, 8'h80, 8'h20, 1'b0, 600);
    pwm_run("R7 inverting", 2'b11, 8'h40, 8'hC0, 1'b1, 600);
    t_gating;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule